// File: doc/BRIEF.md
# Serialized Dual-Read Dual-Write Register File

This block presents a register file with two read ports and two write ports to a cycle-level model, while keeping every entry in a single memory that has one synchronous read port and one write port. One model cycle is accepted through a start/ready handshake. The handshake carries both read indices and both write index/data pairs. A small sequencer then replays the four accesses on the single memory over a fixed three fast clock cycles, and it raises a one-cycle done pulse when both read results are present.

From the model's point of view the reads take no model time. Both values returned for a model cycle are the register contents as they stood before that cycle's writes. The writes take effect before the next model cycle reads anything. If both writes name the same index, the second write port's data is what remains. A new model cycle may be started on the done cycle itself, so back-to-back operation costs exactly three fast clocks per model cycle. Depth and data width are parameters. The memory contents are not cleared by reset.

Top module: `serial_regfile`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `op_ready` is 1 and `op_done` is 0.
- R2: A start is accepted only on a clock edge where `op_start` and `op_ready` are both 1. A start presented while `op_ready` is 0 causes no done pulse and no write to the memory.
- R3: `op_done` is 1 on exactly the third cycle after the edge that accepted a start, and never at any other time.
- R4: `rd_data_a` and `rd_data_b` return the entries at `rd_idx_a` and `rd_idx_b` as they stood before the writes of the same model cycle.
- R5: When `wr_idx_a` equals `wr_idx_b`, the entry afterwards holds `wr_data_b`.
- R6: A read index equal to a write index of the same model cycle returns the old value, not the data being written.
- R7: After a done pulse, `rd_data_a` and `rd_data_b` keep their values on every cycle that the block stays idle.
- R8: `op_ready` is 1 on the done cycle. A start accepted there begins the next model cycle at once, and its reads observe both writes of the previous model cycle.
- R9: `op_done` is a single-cycle pulse, and `op_ready` is 0 on the two cycles after an accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | Request to begin a model cycle |
| op_ready | output | 1 | Block can accept a start this cycle |
| rd_idx_a | input | ADDR_W | First read index |
| rd_idx_b | input | ADDR_W | Second read index |
| wr_idx_a | input | ADDR_W | First write index |
| wr_data_a | input | DATA_W | First write data |
| wr_idx_b | input | ADDR_W | Second write index (wins on equal indices) |
| wr_data_b | input | DATA_W | Second write data |
| rd_data_a | output | DATA_W | First read result |
| rd_data_b | output | DATA_W | Second read result |
| op_done | output | 1 | One-cycle pulse: model cycle complete, read data valid |

## Verification
The bench aims at the collisions that come from sharing one memory port. A read of an index that is written in the same model cycle must see the old value; a design that did not read before it wrote would return the new data there. Two writes to one index must leave the second port's data; reversing the write order would leave the first. Back-to-back model cycles check that the last write lands before the next read. A design that issued the read too early would return stale data. A start raised while the block is busy is followed by reads that would expose a stray write, and by a done count that would expose a stray pulse. Idle gaps check that the results do not drift once done has passed.

// File: rtl/srf_pkg.sv
// Package: shared types for the serialized register file.
// Assumes: the fixed three-step schedule below is the only schedule.
package srf_pkg;

    // Steps of one model cycle on the single memory port.
    typedef enum logic [1:0] {
        STEP_IDLE   = 2'd0,  // waiting for a start
        STEP_RD_A   = 2'd1,  // issue first read
        STEP_RD_B   = 2'd2,  // issue second read, perform first write
        STEP_WR_B   = 2'd3   // perform second write, results valid
    } step_e;

    // Fast clocks spent per model cycle.
    localparam int unsigned STEPS_PER_MODEL_CYCLE = 3;

endpackage

// File: rtl/srf_bram.sv
// Module: srf_bram
// One-read one-write synchronous memory. The read is registered and returns
// the contents from before a write to the same address on the same edge.
// Assumes: the contents are not reset and come up undefined.
module srf_bram #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_q,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Read and write the array on one edge; the nonblocking read sees the old word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/srf_sequencer.sv
// Module: srf_sequencer
// Steps through the three fast cycles of one model cycle and decodes the
// memory-port controls for each step. Accepts a new start when idle or on
// the final step, so model cycles can run back to back.
// Assumes: start is sampled only when ready is high.
module srf_sequencer
    import srf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready,
    output logic accept,
    output logic rd_en,
    output logic rd_sel_b,
    output logic wr_en,
    output logic wr_sel_b,
    output logic cap_a,
    output logic b_live,
    output logic done
);
    step_e step_q, step_d;

    // Decode handshake and port controls from the current step.
    always_comb begin
        ready    = (step_q == STEP_IDLE) || (step_q == STEP_WR_B);
        accept   = start && ready;
        rd_en    = (step_q == STEP_RD_A) || (step_q == STEP_RD_B);
        rd_sel_b = (step_q == STEP_RD_B);
        wr_en    = (step_q == STEP_RD_B) || (step_q == STEP_WR_B);
        wr_sel_b = (step_q == STEP_WR_B);
        cap_a    = (step_q == STEP_RD_B);
        b_live   = (step_q == STEP_WR_B);
        done     = (step_q == STEP_WR_B);
    end

    // Select the following step.
    always_comb begin
        unique case (step_q)
            STEP_IDLE: step_d = accept ? STEP_RD_A : STEP_IDLE;
            STEP_RD_A: step_d = STEP_RD_B;
            STEP_RD_B: step_d = STEP_WR_B;
            STEP_WR_B: step_d = accept ? STEP_RD_A : STEP_IDLE;
            default:   step_d = STEP_IDLE;
        endcase
    end

    // Advance the step register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= STEP_IDLE;
        end else begin
            step_q <= step_d;
        end
    end

endmodule

// File: rtl/srf_op_latch.sv
// Module: srf_op_latch
// Captures the four port requests on an accepted start and steers the one
// that the current step needs onto the memory address and data lines.
// Assumes: inputs need only be valid on the accepting edge.
module srf_op_latch #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] rd_idx_a,
    input  logic [ADDR_W-1:0] rd_idx_b,
    input  logic [ADDR_W-1:0] wr_idx_a,
    input  logic [DATA_W-1:0] wr_data_a,
    input  logic [ADDR_W-1:0] wr_idx_b,
    input  logic [DATA_W-1:0] wr_data_b,
    input  logic              rd_sel_b,
    input  logic              wr_sel_b,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    logic [ADDR_W-1:0] ra_q, rb_q, wa_q, wb_q;
    logic [DATA_W-1:0] da_q, db_q;

    // Hold the request for the duration of the model cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra_q <= '0;
            rb_q <= '0;
            wa_q <= '0;
            wb_q <= '0;
            da_q <= '0;
            db_q <= '0;
        end else if (accept) begin
            ra_q <= rd_idx_a;
            rb_q <= rd_idx_b;
            wa_q <= wr_idx_a;
            wb_q <= wr_idx_b;
            da_q <= wr_data_a;
            db_q <= wr_data_b;
        end
    end

    // Steer the port used by the current step onto the memory.
    always_comb begin
        mem_rd_addr = rd_sel_b ? rb_q : ra_q;
        mem_wr_addr = wr_sel_b ? wb_q : wa_q;
        mem_wr_data = wr_sel_b ? db_q : da_q;
    end

endmodule

// File: rtl/srf_result_hold.sv
// Module: srf_result_hold
// Keeps both read results stable between model cycles. The first result is
// registered one step before done; the second is passed straight from the
// memory on the done step and registered on its closing edge.
// Assumes: the memory output does not change on the done step.
module srf_result_hold #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mem_q,
    input  logic              cap_a,
    input  logic              b_live,
    output logic [DATA_W-1:0] res_a,
    output logic [DATA_W-1:0] res_b
);
    logic [DATA_W-1:0] hold_a_q, hold_b_q;

    // Capture each result at the end of the step that presents it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_a_q <= '0;
            hold_b_q <= '0;
        end else begin
            if (cap_a) begin
                hold_a_q <= mem_q;
            end
            if (b_live) begin
                hold_b_q <= mem_q;
            end
        end
    end

    // Present the held values, bypassing the second one on the done step.
    always_comb begin
        res_a = hold_a_q;
        res_b = b_live ? mem_q : hold_b_q;
    end

endmodule

// File: rtl/serial_regfile.sv
// Module: serial_regfile
// Two-read two-write register file built on one 1R/1W memory. Each model
// cycle takes three fast clocks: read A; read B with write A; write B with
// done. Reads see pre-write contents; write B lands last and wins ties.
// Assumes: the requester holds its inputs valid on the accepting edge only.
module serial_regfile #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    output logic              op_ready,
    input  logic [ADDR_W-1:0] rd_idx_a,
    input  logic [ADDR_W-1:0] rd_idx_b,
    input  logic [ADDR_W-1:0] wr_idx_a,
    input  logic [DATA_W-1:0] wr_data_a,
    input  logic [ADDR_W-1:0] wr_idx_b,
    input  logic [DATA_W-1:0] wr_data_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b,
    output logic              op_done
);
    logic              accept, rd_en, rd_sel_b, wr_en, wr_sel_b, cap_a, b_live;
    logic [ADDR_W-1:0] mem_rd_addr, mem_wr_addr;
    logic [DATA_W-1:0] mem_wr_data, mem_q;

    srf_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (op_start),
        .ready    (op_ready),
        .accept   (accept),
        .rd_en    (rd_en),
        .rd_sel_b (rd_sel_b),
        .wr_en    (wr_en),
        .wr_sel_b (wr_sel_b),
        .cap_a    (cap_a),
        .b_live   (b_live),
        .done     (op_done)
    );

    srf_op_latch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ops (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .rd_idx_a    (rd_idx_a),
        .rd_idx_b    (rd_idx_b),
        .wr_idx_a    (wr_idx_a),
        .wr_data_a   (wr_data_a),
        .wr_idx_b    (wr_idx_b),
        .wr_data_b   (wr_data_b),
        .rd_sel_b    (rd_sel_b),
        .wr_sel_b    (wr_sel_b),
        .mem_rd_addr (mem_rd_addr),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data)
    );

    srf_bram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .rd_en   (rd_en),
        .rd_addr (mem_rd_addr),
        .rd_q    (mem_q),
        .wr_en   (wr_en),
        .wr_addr (mem_wr_addr),
        .wr_data (mem_wr_data)
    );

    srf_result_hold #(.DATA_W(DATA_W)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .mem_q  (mem_q),
        .cap_a  (cap_a),
        .b_live (b_live),
        .res_a  (rd_data_a),
        .res_b  (rd_data_b)
    );

endmodule

// File: rtl/srf_checker.sv
// Module: srf_checker
// Port-level temporal checks for serial_regfile, attached by bind below.
// Assumes: reset is held low for at least two clocks at start-up.
module srf_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_start,
    input logic              op_ready,
    input logic              op_done,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [DATA_W-1:0] rd_data_b
);
    logic taken;
    assign taken = op_start && op_ready;

    // R1: the cycle after a reset cycle is idle and ready.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (op_ready && !op_done));

    // R3: done follows an accepted start after exactly three cycles.
    assert_done_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> ##3 op_done);

    // R3: no done without a start three cycles earlier.
    assert_done_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> $past(taken, 3));

    // R9: busy on the two cycles after acceptance.
    assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> (!op_ready ##1 !op_ready));

    // R9: done lasts one cycle.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    // R8: the done cycle is also a ready cycle.
    assert_ready_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> op_ready);

    // R7: results hold while the block stays idle.
    assert_results_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready && !op_done && $past(op_ready)) |-> $stable({rd_data_a, rd_data_b}));

endmodule

bind serial_regfile srf_checker #(.DATA_W(DATA_W)) u_srf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_start  (op_start),
    .op_ready  (op_ready),
    .op_done   (op_done),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b)
);

// File: tb/serial_regfile_tb_top.sv
// Scoreboard bench: the driver computes expected reads from a behavioural
// two-read two-write array and queues them; the monitor compares on done.
module serial_regfile_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int NREG = 1 << AW;

    typedef struct {
        logic [DW-1:0] exp_a;
        logic [DW-1:0] exp_b;
        int            exp_cyc;
        bit            chk;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_start = 1'b0;
    logic          op_ready, op_done;
    logic [AW-1:0] rd_idx_a = '0, rd_idx_b = '0, wr_idx_a = '0, wr_idx_b = '0;
    logic [DW-1:0] wr_data_a = '0, wr_data_b = '0;
    logic [DW-1:0] rd_data_a, rd_data_b;

    logic [DW-1:0] model [NREG];
    exp_t          exp_q [$];
    int            n_checks = 0;
    int            n_errors = 0;
    int            cyc = 0;
    int            n_sent = 0;
    int            n_done = 0;
    bit            finished = 1'b0;
    logic [DW-1:0] last_a = '0, last_b = '0;
    bit            have_last = 1'b0;

    serial_regfile #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_start  (op_start),
        .op_ready  (op_ready),
        .rd_idx_a  (rd_idx_a),
        .rd_idx_b  (rd_idx_b),
        .wr_idx_a  (wr_idx_a),
        .wr_data_a (wr_data_a),
        .wr_idx_b  (wr_idx_b),
        .wr_data_b (wr_data_b),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b),
        .op_done   (op_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: issue one model cycle at a negedge where the block is ready.
    task automatic run_op(input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                          input logic [AW-1:0] wa, input logic [DW-1:0] da,
                          input logic [AW-1:0] wb, input logic [DW-1:0] db,
                          input bit chk, input string tag);
        exp_t e;
        while (!op_ready) @(negedge clk);
        rd_idx_a  = ra;
        rd_idx_b  = rb;
        wr_idx_a  = wa;
        wr_data_a = da;
        wr_idx_b  = wb;
        wr_data_b = db;
        op_start  = 1'b1;
        e.exp_a   = model[ra];
        e.exp_b   = model[rb];
        e.exp_cyc = cyc + 3;
        e.chk     = chk;
        e.tag     = tag;
        exp_q.push_back(e);
        model[wa] = da;
        model[wb] = db;
        n_sent++;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    // Monitor: compare results on done and check hold while idle.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (op_done) begin
                n_done++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cyc == e.exp_cyc, "R3 done timing", cyc, e.exp_cyc);
                    if (e.chk) begin
                        check(rd_data_a === e.exp_a, {e.tag, " read port a"}, rd_data_a, e.exp_a);
                        check(rd_data_b === e.exp_b, {e.tag, " read port b"}, rd_data_b, e.exp_b);
                    end
                end
                last_a    = rd_data_a;
                last_b    = rd_data_b;
                have_last = 1'b1;
            end else if (op_ready && have_last) begin
                check(rd_data_a === last_a, "R7 hold port a", rd_data_a, last_a);
                check(rd_data_b === last_b, "R7 hold port b", rd_data_b, last_b);
            end
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: idle and ready while in reset.
        check(op_ready === 1'b1, "R1 ready in reset", op_ready, 1);
        check(op_done === 1'b0, "R1 done in reset", op_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(op_ready === 1'b1, "R1 ready after reset", op_ready, 1);
        check(op_done === 1'b0, "R1 done after reset", op_done, 0);

        // Fill every entry; reads of unwritten entries are not compared.
        for (int i = 0; i < NREG; i += 2) begin
            run_op('0, '0, AW'(i), 32'h1000_0000 + DW'(i), AW'(i + 1),
                   32'h1000_0000 + DW'(i + 1), 1'b0, "init");
        end
        repeat (4) @(negedge clk);

        // R5: both writes to one index, then read it back.
        run_op(AW'(3), AW'(4), AW'(9), 32'hAAAA_0001, AW'(9), 32'hBBBB_0002, 1'b1, "R4");
        run_op(AW'(9), AW'(9), AW'(0), 32'h0000_0000, AW'(1), 32'h0000_0001, 1'b1, "R5");

        // R6: reads target the indices being written this model cycle.
        run_op(AW'(12), AW'(13), AW'(12), 32'hC0DE_0012, AW'(13), 32'hC0DE_0013, 1'b1, "R6");
        run_op(AW'(13), AW'(12), AW'(12), 32'hC0DE_1012, AW'(12), 32'hC0DE_2012, 1'b1, "R6");
        run_op(AW'(12), AW'(13), AW'(2), 32'h2, AW'(3), 32'h3, 1'b1, "R5 tie then R6");

        // R8: back-to-back cycles, each read depends on the previous writes.
        for (int i = 0; i < 8; i++) begin
            run_op(AW'(20 + i), AW'(21 + i), AW'(21 + i), 32'hB2B0_0000 + DW'(i),
                   AW'(22 + i), 32'hB2B1_0000 + DW'(i), 1'b1, "R8");
        end
        repeat (3) @(negedge clk);

        // R2: a start raised while busy is ignored.
        run_op(AW'(7), AW'(8), AW'(5), 32'h5555_5555, AW'(6), 32'h6666_6666, 1'b1, "R4");
        check(op_ready === 1'b0, "R2 busy ready", op_ready, 0);
        wr_idx_a  = AW'(7);
        wr_data_a = 32'hDEAD_BEEF;
        wr_idx_b  = AW'(8);
        wr_data_b = 32'hDEAD_BEEF;
        op_start  = 1'b1;
        @(negedge clk);
        op_start  = 1'b0;
        repeat (4) @(negedge clk);
        run_op(AW'(7), AW'(8), AW'(0), 32'h0, AW'(1), 32'h1, 1'b1, "R2 no stray write");

        // R4 and R7: random traffic with random idle gaps.
        for (int i = 0; i < 400; i++) begin
            run_op(AW'($urandom), AW'($urandom), AW'($urandom), DW'($urandom),
                   AW'($urandom), DW'($urandom), 1'b1, "R4 random");
            if (($urandom % 4) == 0) begin
                repeat ($urandom % 5) @(negedge clk);
            end
        end

        for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 results outstanding", exp_q.size(), 0);
        check(n_done == n_sent, "R2 done count", n_done, n_sent);
        report();
    end

endmodule